// File: doc/BRIEF.md
# USB Endpoint Data-Toggle and Stall Tracker

This block keeps, for each endpoint of a small USB device controller, the data PID sequence state and a software-requested stall flag. Every endpoint is configured as IN, OUT or CONTROL. It can also be marked as high-bandwidth isochronous, which allows the DATA2 and MDATA codes. Transaction events arrive as single-cycle strobes, all addressed by one endpoint index. The events are: an IN packet acknowledged by the host, received OUT data landing in a receive bank, software releasing a bank, a SETUP packet, a toggle reset command, an endpoint disable, and a stall request.

For an IN endpoint the tracked value is the PID to use for the next packet sent. For OUT and CONTROL endpoints it is the PID of the data sitting in the bank software currently owns. A small per-endpoint bank ring records which banks hold data and which PID each bank arrived with. A read-only 8-bit status word per endpoint exposes the toggle and the stall flag. A handshake selector tells the protocol engine whether the next transaction on a chosen endpoint should be answered with ACK, NAK or STALL.

Top module: `usb_ep_seq_tracker`

## Requirements
- R1: After reset every endpoint's toggle reads DATA1 and its stall flag reads 0. Endpoint n's status word sits at `status_o[8n+7:8n]`, with the toggle in bits 7:6 (00 DATA0, 01 DATA1, 10 DATA2, 11 MDATA), the stall flag in bit 5, and bits 4:0 always zero.
- R2: On an IN endpoint (type 00), an acknowledged transmission toggles the value between DATA0 and DATA1 on the next clock edge. The IN-acknowledge strobe has no effect on OUT (type 01) or CONTROL (type 10) endpoints.
- R3: On OUT/CONTROL endpoints, received data fills the next free bank in ring order and records its PID. When that bank is the current bank, the toggle takes the received PID. Data aimed at a bank that is still full is dropped. Received-data and release strobes have no effect on IN endpoints.
- R4: A bank release on a full current bank empties it and advances the current bank. The toggle then takes the new current bank's PID if that bank holds data, and otherwise keeps its value. A release of an empty current bank does nothing.
- R5: Received data carrying DATA2 or MDATA is dropped on an endpoint not marked high-bandwidth isochronous, and accepted on one that is.
- R6: A toggle reset command sets the toggle to DATA1 on the next edge. It discards any received-data, release or IN-acknowledge strobe in the same cycle, and it leaves the banks intact.
- R7: An endpoint disable sets the toggle to DATA1 and empties all of that endpoint's banks.
- R8: A stall request sets the stall flag and a SETUP clears it. When both arrive together, the flag ends cleared.
- R9: The handshake for endpoint `hs_ep_i` is STALL (10) while its stall flag is set. Otherwise it is NAK (01) for an IN endpoint whose `in_ready_i` bit is 0, or for an OUT/CONTROL endpoint whose next fill bank is full. In every other case it is ACK (00).
- R10: Strobes change only the endpoint selected by `evt_ep_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_kind_i | input | 2*NUM_EP | Per-endpoint type: 00 IN, 01 OUT, 10 CONTROL (11 acts as OUT) |
| ep_hbiso_i | input | NUM_EP | Per-endpoint high-bandwidth isochronous enable |
| evt_ep_i | input | EPW | Endpoint addressed by the event strobes |
| in_ack_i | input | 1 | IN packet sent and acknowledged |
| rx_wr_i | input | 1 | OUT/SETUP data written into a receive bank |
| rx_pid_i | input | 2 | PID of the received data |
| bank_rel_i | input | 1 | Software released the current bank |
| setup_i | input | 1 | SETUP packet received |
| tog_rst_i | input | 1 | Toggle reset command |
| ep_dis_i | input | 1 | Endpoint disable |
| stall_req_i | input | 1 | Force-stall request |
| hs_ep_i | input | EPW | Endpoint whose next handshake is requested |
| in_ready_i | input | NUM_EP | IN endpoint has a packet ready to send |
| hs_o | output | 2 | Next handshake: 00 ACK, 01 NAK, 10 STALL |
| status_o | output | 8*NUM_EP | Packed per-endpoint status words |

## Verification
The hardest state to reach from the ports is a release that lands on a bank ring whose other bank is full with a different PID, because only then does the toggle jump to a value that was not just written. The stimulus table builds this on purpose. It first fills both banks of an OUT endpoint with distinct PIDs, then offers a third packet that must be dropped, and only then releases the current bank. The same ordering is repeated on a high-bandwidth isochronous endpoint with DATA2 and MDATA, and is followed by a disable and a release on the emptied ring.

// File: rtl/usb_ep_seq_pkg.sv
package usb_ep_seq_pkg;

  typedef enum logic [1:0] {
    EP_IN   = 2'b00,
    EP_OUT  = 2'b01,
    EP_CTRL = 2'b10,
    EP_RSVD = 2'b11
  } ep_kind_e;

  typedef enum logic [1:0] {
    PID_D0 = 2'b00,
    PID_D1 = 2'b01,
    PID_D2 = 2'b10,
    PID_MD = 2'b11
  } pid_code_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_code_e;

  localparam int unsigned STATUS_W = 8;

endpackage

// File: rtl/usb_ep_seq_slot.sv
module usb_ep_seq_slot
  import usb_ep_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] kind_i,
  input  logic       hbiso_i,
  input  logic       sel_i,
  input  logic       in_ack_i,
  input  logic       rx_wr_i,
  input  logic [1:0] rx_pid_i,
  input  logic       bank_rel_i,
  input  logic       setup_i,
  input  logic       tog_rst_i,
  input  logic       ep_dis_i,
  input  logic       stall_req_i,
  output logic [1:0] tog_o,
  output logic       stall_o,
  output logic       fill_busy_o
);

  localparam int unsigned BPW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [BPW-1:0] LAST_BANK = BPW'(NUM_BANKS - 1);

  logic [1:0]                 tog_q, tog_n;
  logic                       stall_q, stall_n;
  logic [NUM_BANKS-1:0]       full_q, full_n;
  logic [NUM_BANKS-1:0][1:0]  pid_q, pid_n;
  logic [BPW-1:0]             cur_q, cur_n;
  logic [BPW-1:0]             wr_q, wr_n;
  logic                       is_in;
  logic                       pid_legal;
  logic                       wr_ok, rel_ok;
  logic                       upd_en;

  function automatic logic [BPW-1:0] ring_next(input logic [BPW-1:0] p);
    return (p == LAST_BANK) ? '0 : p + 1'b1;
  endfunction

  assign is_in     = (kind_i == EP_IN);
  assign pid_legal = hbiso_i | ~rx_pid_i[1];
  assign wr_ok     = rx_wr_i & ~is_in & pid_legal & ~full_q[wr_q];
  assign rel_ok    = bank_rel_i & ~is_in & full_q[cur_q];
  assign upd_en    = sel_i & (in_ack_i | rx_wr_i | bank_rel_i | setup_i |
                              tog_rst_i | ep_dis_i | stall_req_i);

  always_comb begin
    tog_n   = tog_q;
    stall_n = stall_q;
    full_n  = full_q;
    pid_n   = pid_q;
    cur_n   = cur_q;
    wr_n    = wr_q;
    if (setup_i) begin
      stall_n = 1'b0;
    end else if (stall_req_i) begin
      stall_n = 1'b1;
    end
    if (ep_dis_i) begin
      tog_n  = PID_D1;
      full_n = '0;
      cur_n  = '0;
      wr_n   = '0;
    end else if (tog_rst_i) begin
      tog_n = PID_D1;
    end else if (is_in) begin
      if (in_ack_i) tog_n = {1'b0, ~tog_q[0]};
    end else begin
      if (wr_ok) begin
        full_n[wr_q] = 1'b1;
        pid_n[wr_q]  = rx_pid_i;
        wr_n         = ring_next(wr_q);
      end
      if (rel_ok) begin
        full_n[cur_q] = 1'b0;
        cur_n         = ring_next(cur_q);
      end
      if ((wr_ok || rel_ok) && full_n[cur_n]) tog_n = pid_n[cur_n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= PID_D1;
      stall_q <= 1'b0;
      full_q  <= '0;
      pid_q   <= '0;
      cur_q   <= '0;
      wr_q    <= '0;
    end else if (upd_en) begin
      tog_q   <= tog_n;
      stall_q <= stall_n;
      full_q  <= full_n;
      pid_q   <= pid_n;
      cur_q   <= cur_n;
      wr_q    <= wr_n;
    end
  end

  assign tog_o       = tog_q;
  assign stall_o     = stall_q;
  assign fill_busy_o = full_q[wr_q];

  // R2
  in_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && is_in && in_ack_i && !ep_dis_i && !tog_rst_i)
      |=> (tog_o == {1'b0, ~$past(tog_o[0])}));

  // R6
  tog_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && tog_rst_i) |=> (tog_o == PID_D1));

  // R7
  dis_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ep_dis_i) |=> (tog_o == PID_D1 && full_q == '0));

  // R8
  setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && setup_i) |=> !stall_o);

  // R5
  illegal_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rx_wr_i && rx_pid_i[1] && !hbiso_i && !bank_rel_i &&
     !ep_dis_i && !tog_rst_i) |=> ($stable(full_q) && $stable(tog_o)));

  // R10
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> ($stable(tog_o) && $stable(stall_o)));

endmodule

// File: rtl/usb_ep_hs_sel.sv
module usb_ep_hs_sel
  import usb_ep_seq_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned EPW    = 3
) (
  input  logic [NUM_EP-1:0]   stall_i,
  input  logic [NUM_EP-1:0]   fill_busy_i,
  input  logic [2*NUM_EP-1:0] kind_i,
  input  logic [NUM_EP-1:0]   in_ready_i,
  input  logic [EPW-1:0]      ep_i,
  output logic [1:0]          hs_o
);

  logic [1:0] kind_sel;
  logic       nak_sel;

  always_comb begin
    kind_sel = kind_i[2*ep_i +: 2];
    if (kind_sel == EP_IN) nak_sel = ~in_ready_i[ep_i];
    else                   nak_sel = fill_busy_i[ep_i];
    if (stall_i[ep_i])     hs_o = HS_STALL;
    else if (nak_sel)      hs_o = HS_NAK;
    else                   hs_o = HS_ACK;
  end

  // R9
  always_comb begin
    stall_pri_chk: assert (!stall_i[ep_i] || hs_o == HS_STALL);
  end

endmodule

// File: rtl/usb_ep_seq_tracker.sv
module usb_ep_seq_tracker
  import usb_ep_seq_pkg::*;
#(
  parameter int unsigned NUM_EP    = 8,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned EPW       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2*NUM_EP-1:0]          ep_kind_i,
  input  logic [NUM_EP-1:0]            ep_hbiso_i,
  input  logic [EPW-1:0]               evt_ep_i,
  input  logic                         in_ack_i,
  input  logic                         rx_wr_i,
  input  logic [1:0]                   rx_pid_i,
  input  logic                         bank_rel_i,
  input  logic                         setup_i,
  input  logic                         tog_rst_i,
  input  logic                         ep_dis_i,
  input  logic                         stall_req_i,
  input  logic [EPW-1:0]               hs_ep_i,
  input  logic [NUM_EP-1:0]            in_ready_i,
  output logic [1:0]                   hs_o,
  output logic [STATUS_W*NUM_EP-1:0]   status_o
);

  logic [NUM_EP-1:0]      stall_v;
  logic [NUM_EP-1:0]      busy_v;
  logic [NUM_EP-1:0][1:0] tog_v;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic sel;
    assign sel = (evt_ep_i == EPW'(e));

    usb_ep_seq_slot #(.NUM_BANKS(NUM_BANKS)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind_i      (ep_kind_i[2*e +: 2]),
      .hbiso_i     (ep_hbiso_i[e]),
      .sel_i       (sel),
      .in_ack_i    (in_ack_i),
      .rx_wr_i     (rx_wr_i),
      .rx_pid_i    (rx_pid_i),
      .bank_rel_i  (bank_rel_i),
      .setup_i     (setup_i),
      .tog_rst_i   (tog_rst_i),
      .ep_dis_i    (ep_dis_i),
      .stall_req_i (stall_req_i),
      .tog_o       (tog_v[e]),
      .stall_o     (stall_v[e]),
      .fill_busy_o (busy_v[e])
    );

    assign status_o[STATUS_W*e +: STATUS_W] = {tog_v[e], stall_v[e], 5'b00000};
  end

  usb_ep_hs_sel #(.NUM_EP(NUM_EP), .EPW(EPW)) u_hs (
    .stall_i     (stall_v),
    .fill_busy_i (busy_v),
    .kind_i      (ep_kind_i),
    .in_ready_i  (in_ready_i),
    .ep_i        (hs_ep_i),
    .hs_o        (hs_o)
  );

  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (status_o[7:0] == 8'h40));

endmodule

// File: tb/usb_ep_seq_tracker_bench.sv
module usb_ep_seq_tracker_bench;

  localparam int NUM_EP = 8;
  localparam int EPW    = 3;
  localparam int NVEC   = 24;

  // vector: {ep[2:0], ev[6:0], pid[1:0], exp_tog[1:0], exp_stall}
  // ev bits: 0 in_ack, 1 rx_wr, 2 bank_rel, 3 stall_req, 4 setup, 5 tog_rst, 6 ep_dis
  localparam logic [14:0] VEC [NVEC] = '{
    {3'd1, 7'h01, 2'b00, 2'b00, 1'b0},  // R2 IN flip D1->D0
    {3'd1, 7'h01, 2'b00, 2'b01, 1'b0},  // R2 D0->D1
    {3'd1, 7'h01, 2'b00, 2'b00, 1'b0},  // R2
    {3'd2, 7'h02, 2'b00, 2'b00, 1'b0},  // R3 write current bank
    {3'd2, 7'h02, 2'b01, 2'b00, 1'b0},  // R3 write other bank
    {3'd2, 7'h02, 2'b00, 2'b00, 1'b0},  // R3 ring full: dropped
    {3'd2, 7'h04, 2'b00, 2'b01, 1'b0},  // R4 release -> next bank PID
    {3'd2, 7'h04, 2'b00, 2'b01, 1'b0},  // R4 release -> empty bank, keep
    {3'd2, 7'h02, 2'b10, 2'b01, 1'b0},  // R5 DATA2 rejected non-hb
    {3'd2, 7'h02, 2'b00, 2'b00, 1'b0},  // R3 write current bank
    {3'd2, 7'h20, 2'b00, 2'b01, 1'b0},  // R6 toggle reset
    {3'd3, 7'h02, 2'b10, 2'b10, 1'b0},  // R5 DATA2 accepted hb
    {3'd3, 7'h02, 2'b11, 2'b10, 1'b0},  // R5 MDATA into other bank
    {3'd3, 7'h04, 2'b00, 2'b11, 1'b0},  // R4 release -> MDATA
    {3'd3, 7'h40, 2'b00, 2'b01, 1'b0},  // R7 disable
    {3'd3, 7'h04, 2'b00, 2'b01, 1'b0},  // R7 banks empty, release idle
    {3'd0, 7'h08, 2'b00, 2'b01, 1'b1},  // R8 stall set
    {3'd0, 7'h10, 2'b00, 2'b01, 1'b0},  // R8 setup clears
    {3'd0, 7'h18, 2'b00, 2'b01, 1'b0},  // R8 both: setup wins
    {3'd4, 7'h08, 2'b00, 2'b01, 1'b1},  // R8 stall on IN ep
    {3'd1, 7'h02, 2'b00, 2'b00, 1'b0},  // R3 rx_wr ignored on IN
    {3'd2, 7'h01, 2'b00, 2'b01, 1'b0},  // R2 in_ack ignored on OUT
    {3'd2, 7'h04, 2'b00, 2'b01, 1'b0},  // R4 release, next empty
    {3'd1, 7'h21, 2'b00, 2'b01, 1'b0}   // R6 reset beats in_ack
  };

  logic                  clk;
  logic                  rst_n;
  logic [2*NUM_EP-1:0]   ep_kind;
  logic [NUM_EP-1:0]     ep_hbiso;
  logic [EPW-1:0]        evt_ep;
  logic                  in_ack, rx_wr, bank_rel, setup, tog_rst, ep_dis, stall_req;
  logic [1:0]            rx_pid;
  logic [EPW-1:0]        hs_ep;
  logic [NUM_EP-1:0]     in_ready;
  logic [1:0]            hs;
  logic [8*NUM_EP-1:0]   status;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  usb_ep_seq_tracker u_usb_ep_seq_tracker (
    .clk(clk), .rst_n(rst_n), .ep_kind_i(ep_kind), .ep_hbiso_i(ep_hbiso),
    .evt_ep_i(evt_ep), .in_ack_i(in_ack), .rx_wr_i(rx_wr), .rx_pid_i(rx_pid),
    .bank_rel_i(bank_rel), .setup_i(setup), .tog_rst_i(tog_rst),
    .ep_dis_i(ep_dis), .stall_req_i(stall_req), .hs_ep_i(hs_ep),
    .in_ready_i(in_ready), .hs_o(hs), .status_o(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [2:0] ep, input logic [6:0] ev, input logic [1:0] pid);
    @(negedge clk);
    evt_ep = ep; rx_pid = pid;
    {ep_dis, tog_rst, setup, stall_req, bank_rel, rx_wr, in_ack} = ev;
    @(negedge clk);
    {ep_dis, tog_rst, setup, stall_req, bank_rel, rx_wr, in_ack} = '0;
  endtask

  initial begin
    // ep0 CONTROL, ep1 IN, ep2 OUT, ep3 OUT hb-iso, ep4 IN, ep5..7 OUT
    ep_kind  = {2'b01, 2'b01, 2'b01, 2'b00, 2'b01, 2'b01, 2'b00, 2'b10};
    ep_hbiso = 8'b0000_1000;
    evt_ep = '0; rx_pid = '0; hs_ep = '0; in_ready = '0;
    {ep_dis, tog_rst, setup, stall_req, bank_rel, rx_wr, in_ack} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of every endpoint
    for (int e = 0; e < NUM_EP; e++) check("R1", status[8*e +: 8], 32'h40);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      fire(VEC[i][14:12], VEC[i][11:5], VEC[i][4:3]);
      check($sformatf("vec%0d tog", i), status[8*VEC[i][14:12]+6 +: 2], VEC[i][2:1]);
      check($sformatf("vec%0d stall", i), status[8*VEC[i][14:12]+5], VEC[i][0]);
    end

    // R10 untouched endpoints after table
    check("R10 ep5", status[8*5 +: 8], 32'h40);
    check("R10 ep4 stall kept", status[8*4 +: 8], 32'h60);

    // R9 handshake selection
    hs_ep = 3'd4; #1; check("R9 stall", hs, 2'b10);
    hs_ep = 3'd1; in_ready = 8'h00; #1; check("R9 IN not ready NAK", hs, 2'b01);
    in_ready = 8'h02; #1; check("R9 IN ready ACK", hs, 2'b00);
    hs_ep = 3'd5; #1; check("R9 OUT empty ACK", hs, 2'b00);
    fire(3'd5, 7'h02, 2'b00);
    #1; check("R9 one bank free ACK", hs, 2'b00);
    fire(3'd5, 7'h02, 2'b01);
    #1; check("R9 ring full NAK", hs, 2'b01);
    fire(3'd5, 7'h04, 2'b00);
    #1; check("R9 after release ACK", hs, 2'b00);
    check("R4 ep5 tog after release", status[8*5+6 +: 2], 2'b01);
    fire(3'd5, 7'h02, 2'b00);
    fire(3'd5, 7'h40, 2'b00);
    #1; check("R7 disable empties ring", hs, 2'b00);
    check("R7 disable tog", status[8*5+6 +: 2], 2'b01);

    // R6 toggle reset keeps banks: fill ep6, reset, release reveals PID
    fire(3'd6, 7'h02, 2'b00);
    fire(3'd6, 7'h02, 2'b00);
    fire(3'd6, 7'h20, 2'b00);
    check("R6 tog reset", status[8*6+6 +: 2], 2'b01);
    fire(3'd6, 7'h04, 2'b00);
    check("R6 banks survive reset", status[8*6+6 +: 2], 2'b00);

    // R1 async reset mid-run
    rst_n = 1'b0; #3;
    check("R1 async reset", status[8*4 +: 8], 32'h40);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R1 low bits zero", status[8*1 +: 5], 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule